// File: doc/BRIEF.md
# Cascadable Serial Result Read-Out Port

This block is the slave side of a converter's serial read-out. A conversion stage delivers an 18-bit parallel result together with a busy flag. When busy drops, the result is placed in an output shift register. An external host then selects the port and pulses a serial clock to pull the result out one bit at a time, most significant bit first.

A serial cascade input lets several ports share a single host data line. Each port captures its cascade input on the serial clock edge opposite to its shift edge and feeds that bit into the bottom of its register. The downstream port therefore emits its own 18 bits and then, with no gap, the 18 bits of the port wired to its cascade input. A polarity input selects which serial clock edge is the shift edge.

All pins are sampled in the core clock domain. The serial clock is treated as a data signal whose edges the port detects. The host must hold each serial clock level for at least one core clock cycle.

Top module: `cascade_result_port`

## Requirements
- R1: After reset the shift register holds all zeros, and the capture bit is zero, so a read before any conversion returns zeros.
- R2: The result on `conv_data` is copied into the shift register on the core clock edge where `conv_busy` is first seen low after being high. At any other time, a change on `conv_data` has no effect on the register.
- R3: Shift and capture edges are ignored unless `sel_n` and `read_n` are both 0. While either is 1, the register and the capture bit keep their values.
- R4: While `conv_busy` is 1, serial clock edges neither shift nor capture, and the register keeps its previous contents.
- R5: The effective clock is `ser_clk` XOR `ser_clk_inv`. It idles at 1. One pulse is a 1-to-0 transition (the capture edge) followed by a 0-to-1 transition (the shift edge). Each shift edge moves the register one place toward bit 17, so bit 17 is output first and 18 pulses deliver the whole word.
- R6: `ser_out` changes only in the core cycle after a shift edge or a load. The bit shown is therefore the same at the capture edge and at the shift edge of its pulse.
- R7: At each capture edge, `casc_in` is stored. At the next shift edge, that stored bit enters bit 0. After the 18 local bits, the port outputs the captured bits in the order they arrived.
- R8: When two ports share their clock and control inputs, and the downstream port's `casc_in` is driven by the upstream port's `ser_out`, pulses 1 to 18 give the downstream word D17..D0. Pulses 19 to 36 give the upstream word X17..X0.
- R9: With `ser_clk_inv` = 1, a falling `ser_clk` is the shift edge and a rising one is the capture edge. The read-out order is unchanged.
- R10: While `sel_n` is 1, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_busy | input | 1 | Conversion in progress; its falling edge loads the result |
| conv_data | input | RES_W | Parallel conversion result |
| sel_n | input | 1 | Active-low port select |
| read_n | input | 1 | Active-low read enable |
| ser_clk | input | 1 | Host serial clock, sampled by `clk` |
| ser_clk_inv | input | 1 | Selects the falling serial clock edge as the shift edge |
| casc_in | input | 1 | Cascade serial input from the next port up the chain |
| ser_out | output | 1 | Serial data output, 0 when deselected |

## Verification
Two ports are cascaded, and a behavioural model of both is compared on every core cycle.

The main read-out is exercised with two different result words at each clock polarity. This shows that the bit order and the join between the two words are right at both polarities. A constant 1 on the top cascade input makes the bits that follow the 36 data bits distinguishable from reset zeros.

A read is paused by raising select and later by raising read enable, and it must resume at the same bit. Serial pulses are sent during busy, and the result input is changed without a busy edge. In each case the stream that follows shows whether those inputs disturbed the stored bits.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int unsigned RES_W_DEF = 18;

  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
  } crp_ctl_t;
endpackage

// File: rtl/crp_rst_sync.sv
module crp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/crp_edge_track.sv
module crp_edge_track #(
  parameter bit IDLE    = 1'b0,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= prev_d;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~sig_i;
    end else begin : g_rise
      assign edge_o = ~prev_q & sig_i;
    end
  endgenerate
endmodule

// File: rtl/crp_shifter.sv
module crp_shifter
  import crp_pkg::*;
#(
  parameter int unsigned W = RES_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  crp_ctl_t     ctl,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  output logic [W-1:0] bits_o
);
  logic [W-1:0] sr_q, sr_d;
  logic         cap_q, cap_d;

  always_comb begin
    sr_d  = sr_q;
    cap_d = cap_q;
    if (ctl.load)       sr_d = par_i;
    else if (ctl.shift) sr_d = {sr_q[W-2:0], cap_q};
    if (ctl.capture)    cap_d = ser_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cap_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cap_q <= cap_d;
    end
  end

  assign bits_o = sr_q;
endmodule

// File: rtl/cascade_result_port.sv
module cascade_result_port
  import crp_pkg::*;
#(
  parameter int unsigned RES_W = RES_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_busy,
  input  logic [RES_W-1:0] conv_data,
  input  logic             sel_n,
  input  logic             read_n,
  input  logic             ser_clk,
  input  logic             ser_clk_inv,
  input  logic             casc_in,
  output logic             ser_out
);
  logic             core_rst_n;
  logic             eff_clk;
  logic             eff_rise;
  logic             eff_fall;
  logic             busy_fall;
  logic             read_en;
  crp_ctl_t         ctl;
  logic [RES_W-1:0] sr_bits;

  crp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign eff_clk = ser_clk ^ ser_clk_inv;

  crp_edge_track #(.IDLE(1'b1), .FALLING(1'b0)) u_shift_edge (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .sig_i  (eff_clk),
    .edge_o (eff_rise)
  );

  crp_edge_track #(.IDLE(1'b1), .FALLING(1'b1)) u_capture_edge (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .sig_i  (eff_clk),
    .edge_o (eff_fall)
  );

  crp_edge_track #(.IDLE(1'b0), .FALLING(1'b1)) u_busy_edge (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .sig_i  (conv_busy),
    .edge_o (busy_fall)
  );

  always_comb begin
    read_en     = ~sel_n & ~read_n & ~conv_busy;
    ctl.load    = busy_fall;
    ctl.shift   = read_en & eff_rise;
    ctl.capture = read_en & eff_fall;
  end

  crp_shifter #(.W(RES_W)) u_shifter (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .ctl    (ctl),
    .par_i  (conv_data),
    .ser_i  (casc_in),
    .bits_o (sr_bits)
  );

  assign ser_out = sel_n ? 1'b0 : sr_bits[RES_W-1];
endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
  parameter int unsigned RES_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_busy,
  input logic [RES_W-1:0] conv_data,
  input logic             sel_n,
  input logic             read_n,
  input logic             ser_clk,
  input logic             ser_clk_inv,
  input logic             ser_out,
  input logic [RES_W-1:0] sr_bits
);
  logic eff;
  assign eff = ser_clk ^ ser_clk_inv;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy) |=> (sr_bits == $past(conv_data)));

  // R4
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_busy) |-> $stable(sr_bits));

  // R3
  deselect_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sel_n) || $past(read_n)) && !($past(conv_busy, 2) && !$past(conv_busy)))
    |-> $stable(sr_bits));

  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !$past(sel_n) && !($past(eff) && !$past(eff, 2))
     && !($past(conv_busy, 2) && !$past(conv_busy)))
    |-> $stable(ser_out));
endmodule

bind cascade_result_port crp_checker #(.RES_W(RES_W)) u_crp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_busy   (conv_busy),
  .conv_data   (conv_data),
  .sel_n       (sel_n),
  .read_n      (read_n),
  .ser_clk     (ser_clk),
  .ser_clk_inv (ser_clk_inv),
  .ser_out     (ser_out),
  .sr_bits     (sr_bits)
);

// File: tb/cascade_result_port_bench.sv
module cascade_result_port_bench;
  localparam int RW   = 18;
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, busy, sel_n, read_n, sclk, sinv, up_sdi;
  logic [RW-1:0] data_up, data_dn;
  logic          sdo_up, sdo_dn;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  cascade_result_port #(.RES_W(RW)) u_cascade_result_port (
    .clk(clk), .rst_n(rst_n), .conv_busy(busy), .conv_data(data_dn),
    .sel_n(sel_n), .read_n(read_n), .ser_clk(sclk), .ser_clk_inv(sinv),
    .casc_in(sdo_up), .ser_out(sdo_dn)
  );

  cascade_result_port #(.RES_W(RW)) u_cascade_result_port_up (
    .clk(clk), .rst_n(rst_n), .conv_busy(busy), .conv_data(data_up),
    .sel_n(sel_n), .read_n(read_n), .ser_clk(sclk), .ser_clk_inv(sinv),
    .casc_in(up_sdi), .ser_out(sdo_up)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural model: one bit queue per port
  typedef bit bq_t[$];
  bq_t mq_up, mq_dn;
  bit  cap_up, cap_dn, m_busy_prev, m_e_prev;

  function automatic bq_t to_q(input logic [RW-1:0] d);
    bq_t r;
    for (int i = RW - 1; i >= 0; i--) r.push_back(d[i]);
    return r;
  endfunction

  always @(posedge clk) begin : m_step
    bit e, rise, fall, en, bfall, up_now;
    if (!rst_n) begin
      mq_up = to_q('0); mq_dn = to_q('0);
      cap_up = 0; cap_dn = 0; m_busy_prev = 0; m_e_prev = 1;
    end else begin
      e      = sclk ^ sinv;
      rise   = e && !m_e_prev;
      fall   = !e && m_e_prev;
      en     = !sel_n && !read_n && !busy;
      bfall  = m_busy_prev && !busy;
      up_now = sel_n ? 1'b0 : mq_up[0];
      if (bfall) begin
        mq_up = to_q(data_up);
        mq_dn = to_q(data_dn);
      end else if (en && rise) begin
        mq_up.push_back(cap_up); void'(mq_up.pop_front());
        mq_dn.push_back(cap_dn); void'(mq_dn.pop_front());
      end
      if (en && fall) begin
        cap_up = up_sdi;
        cap_dn = up_now;
      end
      m_e_prev    = e;
      m_busy_prev = busy;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_dn, exp_up;
      exp_dn = sel_n ? 1'b0 : mq_dn[0];
      exp_up = sel_n ? 1'b0 : mq_up[0];
      chk(sdo_dn === exp_dn, {cur_req, " downstream cycle"}, 64'(sdo_dn), 64'(exp_dn));
      chk(sdo_up === exp_up, {cur_req, " upstream cycle"}, 64'(sdo_up), 64'(exp_up));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse(output logic a, output logic b);
    tick(1);
    sclk = sinv;               // effective clock low: capture edge
    tick(1);
    a = sdo_dn;
    tick(HALF - 1);
    b = sdo_dn;
    sclk = ~sinv;              // effective clock high: shift edge
    repeat (HALF) @(posedge clk);
  endtask

  task automatic read_bits(input int n, output logic [63:0] got, output bit steady);
    got = '0;
    steady = 1;
    for (int i = 0; i < n; i++) begin
      logic a, b;
      pulse(a, b);
      got = {got[62:0], a};
      if (a !== b) steady = 0;
    end
  endtask

  task automatic convert(input logic [RW-1:0] u, input logic [RW-1:0] d);
    tick(1);
    busy = 1; data_up = u; data_dn = d;
    tick(4);
    busy = 0;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    bit          steady;
    logic [RW-1:0] d1, x1, d2, x2, d3, x3;
    logic a, b;
    d1 = 18'h2D3A5; x1 = 18'h1B6C9;
    d2 = 18'h35A69; x2 = 18'h0C3D2;
    d3 = 18'h12F0E; x3 = 18'h3A1B7;

    rst_n = 0; busy = 0; sel_n = 1; read_n = 1; sclk = 1; sinv = 0;
    up_sdi = 1; data_up = '0; data_dn = '0;
    tick(3);
    rst_n = 1;
    tick(4);

    // R10: deselected output is 0
    cur_req = "R10";
    chk(sdo_dn === 1'b0, "R10 deselected after reset", 64'(sdo_dn), 64'd0);

    // R1: read before any conversion gives zeros
    cur_req = "R1";
    sel_n = 0; read_n = 0;
    tick(1);
    chk(sdo_dn === 1'b0, "R1 first bit after reset", 64'(sdo_dn), 64'd0);
    read_bits(4, got, steady);
    chk(got[3:0] == 4'h0, "R1 zero read-out", got, 64'd0);

    // R4: pulses during busy neither shift nor capture
    cur_req = "R4";
    tick(1);
    busy = 1; data_up = x1; data_dn = d1;
    tick(2);
    for (int i = 0; i < 3; i++) pulse(a, b);
    tick(1);
    chk(sdo_dn === 1'b0, "R4 output held during busy", 64'(sdo_dn), 64'd0);

    // R2: load on busy falling edge
    cur_req = "R2";
    busy = 0;
    tick(1);
    chk(sdo_dn === d1[RW-1], "R2 MSB after busy fall", 64'(sdo_dn), 64'(d1[RW-1]));

    // R5, R6, R7, R8: cascaded read of 38 pulses
    cur_req = "R8";
    read_bits(38, got, steady);
    chk(got[37:20] == 64'(d1), "R5 local word MSB first", 64'(got[37:20]), 64'(d1));
    chk(got[19:2] == 64'(x1), "R8 upstream word follows", 64'(got[19:2]), 64'(x1));
    chk(got[1:0] == 2'b11, "R7 cascade bits after both words", 64'(got[1:0]), 64'd3);
    chk(steady, "R6 bit steady across pulse", 64'(steady), 64'd1);

    // R3: pauses by select and read enable; R2: data change without busy edge
    cur_req = "R3";
    convert(x2, d2);
    read_bits(5, got, steady);
    chk(got[4:0] == 64'(d2[17:13]), "R3 first five bits", 64'(got[4:0]), 64'(d2[17:13]));
    tick(1);
    sel_n = 1;
    tick(1);
    chk(sdo_dn === 1'b0, "R10 deselected mid read", 64'(sdo_dn), 64'd0);
    for (int i = 0; i < 4; i++) pulse(a, b);
    tick(1);
    sel_n = 0;
    tick(1);
    chk(sdo_dn === d2[12], "R3 resume after select pause", 64'(sdo_dn), 64'(d2[12]));
    read_n = 1;
    for (int i = 0; i < 3; i++) pulse(a, b);
    tick(1);
    read_n = 0;
    data_dn = 18'h3FFFF; data_up = 18'h00000;
    tick(1);
    chk(sdo_dn === d2[12], "R2 data change ignored without busy edge", 64'(sdo_dn), 64'(d2[12]));
    read_bits(31, got, steady);
    chk(got[30:18] == 64'(d2[12:0]), "R3 rest of local word", 64'(got[30:18]), 64'(d2[12:0]));
    chk(got[17:0] == 64'(x2), "R3 cascade word intact after pauses", 64'(got[17:0]), 64'(x2));

    // R9: inverted serial clock polarity
    cur_req = "R9";
    tick(1);
    sinv = 1; sclk = 0;
    tick(2);
    convert(x3, d3);
    read_bits(36, got, steady);
    chk(got[35:0] == {28'd0, d3, x3}, "R9 chained read with inverted clock",
        64'(got[35:0]), 64'({d3, x3}));
    chk(steady, "R6 bit steady with inverted clock", 64'(steady), 64'd1);

    tick(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule